// File: doc/BRIEF.md
# Time-Shared Integration Step Engine

This block advances a second-order differential equation by one integration step. It takes a state (`x`, `u`, `y`), a step size `dx` and an upper bound `a`. It returns the next state and a flag that tells whether the new `x` is still below the bound. Eleven arithmetic operations make up one step. They run over four control steps on only two multipliers and two add/subtract/compare units. A one-hot step counter in the controller selects each unit's operands according to a fixed schedule. Each partial result is stored in its own register at the end of the step that produces it.

The operands enter through a valid/ready handshake. `in_ready` is high only while the engine is idle. A word is taken on a cycle where `in_valid` and `in_ready` are both high. While a computation runs, `in_ready` stays low, which back-pressures the source, and anything presented on the operand inputs is ignored. The result side has no handshake: `done` pulses once, and the result registers then hold their values until the next accepted word.

In repeat mode, each finished step is fed back as the next state for as long as the flag is set. `done` pulses only after the step whose flag is clear.

Top module: `ode_step_core`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, and all four result outputs are 0.
- R2: `in_ready` is 1 exactly when no computation is in progress. Operands are captured only when `in_valid` and `in_ready` are both high. Values presented while `in_ready` is low have no effect on the results.
- R3: In single mode (`loop_en`=0 at acceptance), `done` is high in the 4th cycle after the accepting clock edge, and it stays high for exactly one cycle.
- R4: `x_out` = x + dx, truncated to 16 bits with two's-complement wrap.
- R5: `u_out` = u − 3·x·u·dx − 3·y·dx. Every product and every difference is truncated to 16 bits.
- R6: `y_out` = y + u·dx, truncated to 16 bits.
- R7: `below_out` is 1 when `x_out` < a as signed 16-bit values, and 0 otherwise.
- R8: While the engine is idle and no word is accepted, all result outputs keep their values, whatever the operand inputs do.
- R9: In repeat mode (`loop_en`=1 at acceptance), the next x, u and y replace the state after any step whose flag is 1. `done` pulses 4·N cycles after acceptance, where N is the number of steps up to and including the first one whose flag is 0. The outputs then show that step's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand word valid |
| in_ready | output | 1 | Engine idle, can accept a word |
| loop_en | input | 1 | Repeat-until-bound mode, sampled at acceptance |
| x_in | input | 16 | State x |
| u_in | input | 16 | State u (derivative) |
| y_in | input | 16 | State y |
| dx_in | input | 16 | Step size |
| a_in | input | 16 | Upper bound for x, signed |
| done | output | 1 | One-cycle pulse when results are ready |
| x_out | output | 16 | Next x |
| u_out | output | 16 | Next u |
| y_out | output | 16 | Next y |
| below_out | output | 1 | Next x is below the bound |

## Verification
The hardest case to reach from the ports is the feedback path of repeat mode. There, the state registers are reloaded from the final-step ALU results while the flag from step 2 of the same step decides whether to run again. The bench starts a slow ramp with a positive step and a bound several steps away. It computes the number of steps and the final state by iterating the formulas itself, and it checks both the latency of 4·N cycles and the final values. A second case presents a different operand word while the engine is busy, to show that a held-off source leaves no trace in the result.

// File: rtl/ode_step_pkg.sv
package ode_step_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_LT  = 2'd2,
    ALU_PASS = 2'd3
  } alu_op_e;

  localparam int NUM_STEPS = 4;
  localparam int NUM_MUL   = 2;
  localparam int NUM_ALU   = 2;
endpackage

// File: rtl/ode_mul_lane.sv
module ode_mul_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] prod
);
  logic [2*W-1:0] full;
  assign full = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
  // low half is identical for signed and unsigned operands
  assign prod = full[W-1:0];
endmodule

// File: rtl/ode_alu_lane.sv
module ode_alu_lane
  import ode_step_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_LT:  res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = opa;
    endcase
  end
endmodule

// File: rtl/ode_step_ctrl.sv
module ode_step_ctrl #(
  parameter int NSTEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             again,
  output logic [NSTEP-1:0] step,
  output logic             busy,
  output logic             done
);
  localparam logic [NSTEP-1:0] FIRST = NSTEP'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= step[NSTEP-1] & ~again;
      if (step == '0) begin
        step <= launch ? FIRST : '0;
      end else if (step[NSTEP-1]) begin
        step <= again ? FIRST : '0;
      end else begin
        step <= step << 1;
      end
    end
  end

  assign busy = |step;

  a_r3_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step));
  a_r3_launch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> (step == FIRST));
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step[NSTEP-1]));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/ode_step_core.sv
module ode_step_core
  import ode_step_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         loop_en,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] a_in,
  output logic         done,
  output logic [W-1:0] x_out,
  output logic [W-1:0] u_out,
  output logic [W-1:0] y_out,
  output logic         below_out
);
  localparam logic [W-1:0] K3 = W'(3);

  // latched operands / loop state
  logic [W-1:0] x_q, u_q, y_q, dx_q, a_q;
  logic         loop_q;
  // partial results, one per producing op
  logic [W-1:0] p_3x, p_udx, p_3xudx, p_3y, p_3ydx, p_udx2, d_u3x;
  // result registers
  logic [W-1:0] xn_q, un_q, yn_q;
  logic         c_q;

  logic [NUM_STEPS-1:0] step;
  logic busy, accept, again;

  logic [W-1:0] mul_a [NUM_MUL];
  logic [W-1:0] mul_b [NUM_MUL];
  logic [W-1:0] mul_y [NUM_MUL];
  alu_op_e      alu_op [NUM_ALU];
  logic [W-1:0] alu_a  [NUM_ALU];
  logic [W-1:0] alu_b  [NUM_ALU];
  logic [W-1:0] alu_y  [NUM_ALU];

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign again    = step[NUM_STEPS-1] & loop_q & c_q;

  ode_step_ctrl #(.NSTEP(NUM_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(accept), .again(again),
    .step(step), .busy(busy), .done(done)
  );

  // operand selection from the one-hot step, per the fixed binding
  always_comb begin
    for (int i = 0; i < NUM_MUL; i++) begin
      mul_a[i] = '0;
      mul_b[i] = '0;
    end
    for (int i = 0; i < NUM_ALU; i++) begin
      alu_op[i] = ALU_PASS;
      alu_a[i]  = '0;
      alu_b[i]  = '0;
    end
    if (step[0]) begin
      mul_a[0] = K3;    mul_b[0] = x_q;           // 3x
      mul_a[1] = u_q;   mul_b[1] = dx_q;          // u*dx
      alu_op[0] = ALU_ADD; alu_a[0] = x_q; alu_b[0] = dx_q;  // x+dx
    end
    if (step[1]) begin
      mul_a[0] = p_3x;  mul_b[0] = p_udx;         // 3x*u*dx
      mul_a[1] = K3;    mul_b[1] = y_q;           // 3y
      alu_op[0] = ALU_LT; alu_a[0] = xn_q; alu_b[0] = a_q;   // flag
    end
    if (step[2]) begin
      mul_a[0] = p_3y;  mul_b[0] = dx_q;          // 3y*dx
      mul_a[1] = u_q;   mul_b[1] = dx_q;          // u*dx for y
      alu_op[0] = ALU_SUB; alu_a[0] = u_q; alu_b[0] = p_3xudx;
    end
    if (step[3]) begin
      alu_op[0] = ALU_SUB; alu_a[0] = d_u3x; alu_b[0] = p_3ydx;
      alu_op[1] = ALU_ADD; alu_a[1] = y_q;   alu_b[1] = p_udx2;
    end
  end

  for (genvar g = 0; g < NUM_MUL; g++) begin : g_mul
    ode_mul_lane #(.W(W)) u_mul (.opa(mul_a[g]), .opb(mul_b[g]), .prod(mul_y[g]));
  end
  for (genvar g = 0; g < NUM_ALU; g++) begin : g_alu
    ode_alu_lane #(.W(W)) u_alu (.op(alu_op[g]), .opa(alu_a[g]), .opb(alu_b[g]), .res(alu_y[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0; u_q <= '0; y_q <= '0; dx_q <= '0; a_q <= '0; loop_q <= 1'b0;
      p_3x <= '0; p_udx <= '0; p_3xudx <= '0; p_3y <= '0;
      p_3ydx <= '0; p_udx2 <= '0; d_u3x <= '0;
      xn_q <= '0; un_q <= '0; yn_q <= '0; c_q <= 1'b0;
    end else begin
      if (accept) begin
        x_q <= x_in; u_q <= u_in; y_q <= y_in; dx_q <= dx_in; a_q <= a_in;
        loop_q <= loop_en;
      end
      if (step[0]) begin
        p_3x  <= mul_y[0];
        p_udx <= mul_y[1];
        xn_q  <= alu_y[0];
      end
      if (step[1]) begin
        p_3xudx <= mul_y[0];
        p_3y    <= mul_y[1];
        c_q     <= alu_y[0][0];
      end
      if (step[2]) begin
        p_3ydx <= mul_y[0];
        p_udx2 <= mul_y[1];
        d_u3x  <= alu_y[0];
      end
      if (step[3]) begin
        un_q <= alu_y[0];
        yn_q <= alu_y[1];
        if (again) begin
          x_q <= xn_q;
          u_q <= alu_y[0];
          y_q <= alu_y[1];
        end
      end
    end
  end

  assign x_out     = xn_q;
  assign u_out     = un_q;
  assign y_out     = yn_q;
  assign below_out = c_q;

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> $stable({x_out, u_out, y_out, below_out}));
  a_r7_flag_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (below_out == ($signed(x_out) < $signed(a_q))));
  a_r4_x_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (x_out == W'(x_q + dx_q)));
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step[NUM_STEPS-1]) |=> $stable({dx_q, a_q, loop_q}));
endmodule

// File: tb/tb_ode_step_core.sv
module tb_ode_step_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, loop_en = 1'b0;
  logic [15:0] x_in = '0, u_in = '0, y_in = '0, dx_in = '0, a_in = '0;
  logic in_ready, done, below_out;
  logic [15:0] x_out, u_out, y_out;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  ode_step_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .loop_en(loop_en), .x_in(x_in), .u_in(u_in), .y_in(y_in), .dx_in(dx_in),
    .a_in(a_in), .done(done), .x_out(x_out), .u_out(u_out), .y_out(y_out),
    .below_out(below_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] x, u, y, dx, a, input bit lp,
                       output logic [15:0] xo, uo, yo, output logic co, output int it);
    logic [15:0] cx, cu, cy;
    cx = x; cu = u; cy = y; it = 0;
    forever begin
      it++;
      xo = cx + dx;
      uo = cu - 16'(16'd3 * cx * cu * dx) - 16'(16'd3 * cy * dx);
      yo = cy + 16'(cu * dx);
      co = $signed(xo) < $signed(a);
      if (!(lp && co) || it > 50) break;
      cx = xo; cu = uo; cy = yo;
    end
  endtask

  task automatic run(input logic [15:0] x, u, y, dx, a, input bit lp, input bit poke);
    logic [15:0] ex, eu, ey; logic ec; int it, n;
    model(x, u, y, dx, a, lp, ex, eu, ey, ec, it);
    @(negedge clk);
    check("R2 ready before launch", in_ready, 1);
    x_in = x; u_in = u; y_in = y; dx_in = dx; a_in = a; loop_en = lp; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    if (poke) begin
      check("R2 ready low while busy", in_ready, 0);
      x_in = 16'h1234; u_in = 16'h0777; y_in = 16'h0042; dx_in = 16'h0005;
      a_in = 16'h8000; loop_en = 1; in_valid = 1;
    end
    n = 0;
    while (n < 400) begin
      n++;
      @(posedge clk);
      @(negedge clk);
      if (done) break;
    end
    in_valid = 0;
    if (lp) check("R9 repeat latency", n, 4 * it);
    else    check("R3 latency", n, 4);
    check("R4 x_out", x_out, ex);
    check("R5 u_out", u_out, eu);
    check("R6 y_out", y_out, ey);
    check("R7 below_out", below_out, ec);
    @(negedge clk);
    check("R3 done one cycle", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] vals [4];
    logic [15:0] avals [2];
    logic [15:0] hx, hu, hy; logic hc;
    vals[0] = 16'd0; vals[1] = 16'd1; vals[2] = 16'hFFFD; vals[3] = 16'h7FFF;
    avals[0] = 16'd2; avals[1] = 16'h8000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", in_ready, 1);
    check("R1 done", done, 0);
    check("R1 outputs", {x_out, u_out, y_out, 15'd0, below_out}, 64'd0);
    rst_n = 1;

    // R3..R7 sweep
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          for (int m = 0; m < 4; m++)
            for (int q = 0; q < 2; q++)
              run(vals[i], vals[j], vals[k], vals[m], avals[q], 0, 0);

    // R2: word offered while busy is ignored
    run(16'd7, 16'hFFFE, 16'd9, 16'd4, 16'd100, 0, 1);
    run(16'h8000, 16'd3, 16'hFFFF, 16'd2, 16'd0, 0, 1);

    // R8: idle outputs hold while inputs change
    hx = x_out; hu = u_out; hy = y_out; hc = below_out;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      x_in = 16'(t * 977); u_in = 16'(t * 31); a_in = 16'(t * 5000); in_valid = 0;
    end
    @(negedge clk);
    check("R8 hold x", x_out, hx);
    check("R8 hold u", u_out, hu);
    check("R8 hold y", y_out, hy);
    check("R8 hold c", below_out, hc);

    // R9 repeat mode: ramp reaches bound after several steps
    run(16'd0, 16'd1, 16'd0, 16'd3, 16'd10, 1, 0);
    run(16'hFFF0, 16'd0, 16'd2, 16'd1, 16'hFFF4, 1, 0);
    run(16'd20, 16'd1, 16'd1, 16'd2, 16'd5, 1, 0);   // flag clear on first step
    run(16'd1, 16'd2, 16'd3, 16'd7, 16'd60, 1, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule